// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Scalar Core

This block is a small 32-bit processor. It completes one instruction in each clock cycle. On every rising edge it takes the instruction word at the current program counter from an internal instruction array. It then decodes the word and updates the architectural state: the program counter, a 32 x 32-bit register file and a word-organised data array. It supports two memory operations (load word, store word), two arithmetic operations (add, subtract), one conditional branch (branch-if-equal) and two unconditional transfers (jump, jump-and-link).

Every instruction word is 32 bits wide. Bits [31:26] always hold the opcode, and the opcode selects one of three layouts. Fields that play the same role sit at the same bit positions in every layout, so the decode logic stays shallow. The instruction and data arrays start with no content. The environment fills them before it releases reset. A debug port shows the current program counter and the register-file write port, so that each retired instruction can be observed from outside.

Top module: `tsc_core`

## Requirements
- R1: Register layout: opcode [31:26], source A [25:21], source B [20:16], destination [15:11], unused [10:6], function [5:0]. Opcode 0x00 with function 0x20 writes destination = A + B. For example, word 0x00AF8020 writes register 16 with register 5 + register 15.
- R2: Opcode 0x00 with function 0x22 writes destination = A - B, with 32-bit wrap-around.
- R3: Immediate layout: opcode [31:26], base [25:21], target register [20:16], 16-bit offset [15:0], sign-extended. Opcode 0x23 loads the data word at byte address base + offset into the target register.
- R4: Opcode 0x2B stores the target register to byte address base + offset and writes no register.
- R5: Opcode 0x04, when registers [25:21] and [20:16] are equal, sets the next PC to PC + 4 + 4 x sign-extended offset.
- R6: A branch-if-equal whose operands differ, and every non-transfer instruction, sets the next PC to PC + 4.
- R7: Jump layout: opcode [31:26], target [25:0]. Opcode 0x02 sets PC = {(PC+4)[31:28], target, 2'b00}.
- R8: Opcode 0x03 makes the same transfer as R7 and writes PC + 4 into register 31.
- R9: Register 0 always reads as zero. A write that names it has no effect.
- R10: An undefined opcode, or opcode 0x00 with a function other than 0x20 or 0x22, writes nothing and advances the PC by 4.
- R11: A synchronous active-high reset sets the PC to 0 and clears all 32 registers.
- R12: The debug port shows the PC of the instruction now executing, and the register write (enable, index, data) that this instruction commits at the next rising edge. The enable stays low for writes aimed at register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Address of the instruction executing this cycle |
| dbg_wr_en | output | 1 | A register is written at the coming edge |
| dbg_wr_addr | output | 5 | Index of the register being written |
| dbg_wr_data | output | 32 | Value being written |

## Verification
On every cycle, the assertions check these properties: the program counter stays word-aligned; it advances by exactly four unless a transfer is taken; a taken branch lands on the scaled PC-relative target; a link always goes to register 31 with PC + 4; a store never reports a register write; register 0 holds zero; and reset returns the PC and registers to zero. Only the scenarios can show that arithmetic results, sign-extended load addresses, store-then-load round trips, jump targets and the no-op handling of unknown encodings produce the correct values, because that needs programs with known expected results.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int XLEN   = 32;
  localparam int NREGS  = 32;
  localparam int RIDX_W = $clog2(NREGS);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JMP   = 6'h02;
  localparam logic [5:0] OP_JAL   = 6'h03;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] FN_ADD   = 6'h20;
  localparam logic [5:0] FN_SUB   = 6'h22;

  localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(NREGS - 1);

  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;
  typedef enum logic [1:0] {DST_RD, DST_RT, DST_LINK} dst_sel_e;

  typedef struct packed {
    logic     reg_we;
    wb_sel_e  wb_sel;
    dst_sel_e dst_sel;
    logic     alu_sub;
    logic     use_imm;
    logic     mem_we;
    logic     branch;
    logic     jump;
  } ctrl_t;
endpackage

// File: rtl/tsc_decode.sv
module tsc_decode
  import tsc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);
  always_comb begin
    ctl         = '0;
    ctl.wb_sel  = WB_ALU;
    ctl.dst_sel = DST_RD;
    unique case (opcode)
      OP_RTYPE: begin
        if (funct == FN_ADD) begin
          ctl.reg_we = 1'b1;
        end else if (funct == FN_SUB) begin
          ctl.reg_we  = 1'b1;
          ctl.alu_sub = 1'b1;
        end
      end
      OP_LOAD: begin
        ctl.reg_we  = 1'b1;
        ctl.wb_sel  = WB_MEM;
        ctl.dst_sel = DST_RT;
        ctl.use_imm = 1'b1;
      end
      OP_STORE: begin
        ctl.mem_we  = 1'b1;
        ctl.use_imm = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch  = 1'b1;
        ctl.alu_sub = 1'b1;
      end
      OP_JMP: ctl.jump = 1'b1;
      OP_JAL: begin
        ctl.jump    = 1'b1;
        ctl.reg_we  = 1'b1;
        ctl.wb_sel  = WB_LINK;
        ctl.dst_sel = DST_LINK;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tsc_alu.sv
module tsc_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    y    = sub ? (a - b) : (a + b);
    zero = (y == '0);
  end
endmodule

// File: rtl/tsc_regfile.sv
module tsc_regfile #(
  parameter int W = 32,
  parameter int N = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [$clog2(N)-1:0] waddr,
  input  logic [W-1:0]         wdata,
  input  logic [$clog2(N)-1:0] raddr_a,
  input  logic [$clog2(N)-1:0] raddr_b,
  output logic [W-1:0]         rdata_a,
  output logic [W-1:0]         rdata_b
);
  localparam int AW = $clog2(N);

  logic [W-1:0] regs_q [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs_q[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs_q[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata_a = (raddr_a == AW'(0)) ? '0 : regs_q[raddr_a];
    rdata_b = (raddr_b == AW'(0)) ? '0 : regs_q[raddr_b];
  end

  // R9: the storage behind index 0 never takes a value
  a_r9_reg0_zero: assert property (@(posedge clk) disable iff (rst)
    regs_q[0] == '0);

  // R11: reset empties the register file
  a_r11_regs_cleared: assert property (@(posedge clk)
    rst |=> (regs_q[N-1] == '0) && (regs_q[1] == '0));
endmodule

// File: rtl/tsc_core.sv
module tsc_core
  import tsc_pkg::*;
#(
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 256
) (
  input  logic              clk,
  input  logic              rst,
  output logic [XLEN-1:0]   dbg_pc,
  output logic              dbg_wr_en,
  output logic [RIDX_W-1:0] dbg_wr_addr,
  output logic [XLEN-1:0]   dbg_wr_data
);
  localparam int IA = $clog2(IMEM_WORDS);
  localparam int DA = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] imem_q [IMEM_WORDS];
  logic [XLEN-1:0] dmem_q [DMEM_WORDS];

  initial begin
    for (int i = 0; i < IMEM_WORDS; i++) imem_q[i] = '0;
  end

  logic [XLEN-1:0]   pc_q, pc_plus4, pc_next, instr;
  logic [XLEN-1:0]   rs_val, rt_val, imm_sext, alu_b, alu_y;
  logic [XLEN-1:0]   load_val, wb_data, branch_tgt, jump_tgt;
  logic [RIDX_W-1:0] wb_addr;
  logic              wb_en, alu_zero, take_branch;
  ctrl_t             ctl;

  assign instr = imem_q[pc_q[2 +: IA]];

  tsc_decode u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctl    (ctl)
  );

  tsc_regfile #(.W(XLEN), .N(NREGS)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (wb_en),
    .waddr   (wb_addr),
    .wdata   (wb_data),
    .raddr_a (instr[25:21]),
    .raddr_b (instr[20:16]),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  always_comb begin
    imm_sext = {{16{instr[15]}}, instr[15:0]};
    alu_b    = ctl.use_imm ? imm_sext : rt_val;
  end

  tsc_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .sub  (ctl.alu_sub),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign load_val = dmem_q[alu_y[2 +: DA]];

  always_ff @(posedge clk) begin
    if (ctl.mem_we && !rst) dmem_q[alu_y[2 +: DA]] <= rt_val;
  end

  always_comb begin
    unique case (ctl.dst_sel)
      DST_RT:   wb_addr = instr[20:16];
      DST_LINK: wb_addr = LINK_REG;
      default:  wb_addr = instr[15:11];
    endcase
    unique case (ctl.wb_sel)
      WB_MEM:  wb_data = load_val;
      WB_LINK: wb_data = pc_plus4;
      default: wb_data = alu_y;
    endcase
    wb_en = ctl.reg_we && (wb_addr != '0);
  end

  always_comb begin
    pc_plus4    = pc_q + XLEN'(4);
    branch_tgt  = pc_plus4 + (imm_sext << 2);
    jump_tgt    = {pc_plus4[31:28], instr[25:0], 2'b00};
    take_branch = ctl.branch && alu_zero;
    if (ctl.jump)       pc_next = jump_tgt;
    else if (take_branch) pc_next = branch_tgt;
    else                pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign dbg_pc      = pc_q;
  assign dbg_wr_en   = wb_en;
  assign dbg_wr_addr = wb_addr;
  assign dbg_wr_data = wb_data;

  // R11: reset returns the PC to zero
  a_r11_reset_pc: assert property (@(posedge clk) rst |=> (pc_q == '0));

  // R6: PC stays word aligned
  a_r6_pc_aligned: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00);

  // R6: no transfer taken means a plain four-byte step
  a_r6_seq_step: assert property (@(posedge clk) disable iff (rst)
    (!ctl.jump && !(ctl.branch && (rs_val == rt_val))) |=> (pc_q == $past(pc_q) + 32'd4));

  // R5: taken branch lands on the scaled relative target
  a_r5_branch_target: assert property (@(posedge clk) disable iff (rst)
    (ctl.branch && (rs_val == rt_val)) |=>
      (pc_q == $past(pc_q) + 32'd4 + {$past(imm_sext[29:0]), 2'b00}));

  // R8: link writes go to the top register with the return address
  a_r8_link_write: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == OP_JAL) |->
      (dbg_wr_en && (dbg_wr_addr == LINK_REG) && (dbg_wr_data == pc_q + 32'd4)));

  // R4: a store never reports a register write
  a_r4_store_no_write: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == OP_STORE) |-> !dbg_wr_en);
endmodule

// File: tb/tsc_core_test.sv
module tsc_core_test;
  import tsc_pkg::*;

  localparam int IW = 256;
  localparam int DW = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] dbg_pc, dbg_wr_data;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tsc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) uut (
    .clk         (clk),
    .rst         (rst),
    .dbg_pc      (dbg_pc),
    .dbg_wr_en   (dbg_wr_en),
    .dbg_wr_addr (dbg_wr_addr),
    .dbg_wr_data (dbg_wr_data)
  );

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {OP_RTYPE, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] tgt);
    return {op, tgt};
  endfunction

  task automatic chk_pc(input string req, input logic [31:0] exp);
    checks++;
    if (dbg_pc !== exp) begin
      fails++;
      $display("FAIL %s pc: actual %h expected %h", req, dbg_pc, exp);
    end
  endtask

  task automatic chk_wr(input string req, input logic en, input logic [4:0] addr, input logic [31:0] data);
    checks++;
    if (dbg_wr_en !== en || (en && (dbg_wr_addr !== addr || dbg_wr_data !== data))) begin
      fails++;
      $display("FAIL %s write: actual en=%0b r%0d=%h expected en=%0b r%0d=%h",
               req, dbg_wr_en, dbg_wr_addr, dbg_wr_data, en, addr, data);
    end
  endtask

  task automatic clear_mem();
    rst = 1'b1;
    for (int i = 0; i < IW; i++) uut.imem_q[i] = '0;
    for (int i = 0; i < DW; i++) uut.dmem_q[i] = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic test_arith();
    clear_mem();
    uut.dmem_q[0] = 32'd100;
    uut.dmem_q[1] = 32'd37;
    uut.dmem_q[2] = 32'd12;
    uut.imem_q[0] = enc_i(OP_LOAD, 0, 5, 16'd0);
    uut.imem_q[1] = enc_i(OP_LOAD, 0, 15, 16'd4);
    uut.imem_q[2] = 32'h00AF8020;
    uut.imem_q[3] = enc_r(5, 15, 17, FN_SUB);
    uut.imem_q[4] = enc_r(15, 5, 18, FN_SUB);
    uut.imem_q[5] = enc_i(OP_LOAD, 0, 7, 16'd8);
    uut.imem_q[6] = enc_i(OP_LOAD, 7, 8, 16'hFFF8);
    do_reset();
    chk_pc("R11", 32'd0);
    chk_wr("R3", 1'b1, 5'd5, 32'd100);        step();
    chk_pc("R6", 32'd4);
    chk_wr("R3", 1'b1, 5'd15, 32'd37);        step();
    chk_wr("R1", 1'b1, 5'd16, 32'd137);       step();
    chk_wr("R2", 1'b1, 5'd17, 32'd63);        step();
    chk_wr("R2", 1'b1, 5'd18, 32'hFFFF_FFC1); step();
    chk_wr("R3", 1'b1, 5'd7, 32'd12);         step();
    chk_pc("R6", 32'd24);
    chk_wr("R3", 1'b1, 5'd8, 32'd37);         step();
  endtask

  task automatic test_store();
    clear_mem();
    uut.dmem_q[0] = 32'hDEAD_BEEF;
    uut.dmem_q[5] = 32'd20;
    uut.imem_q[0] = enc_i(OP_LOAD, 0, 1, 16'd0);
    uut.imem_q[1] = enc_i(OP_STORE, 0, 1, 16'd12);
    uut.imem_q[2] = enc_i(OP_LOAD, 0, 2, 16'd12);
    uut.imem_q[3] = enc_i(OP_LOAD, 0, 3, 16'd20);
    uut.imem_q[4] = enc_i(OP_STORE, 3, 2, 16'hFFFC);
    uut.imem_q[5] = enc_i(OP_LOAD, 0, 4, 16'd16);
    do_reset();
    step();
    chk_wr("R4", 1'b0, 5'd0, 32'd0); step();
    chk_wr("R4", 1'b1, 5'd2, 32'hDEAD_BEEF); step();
    step();
    chk_wr("R4", 1'b0, 5'd0, 32'd0); step();
    chk_wr("R4", 1'b1, 5'd4, 32'hDEAD_BEEF); step();
  endtask

  task automatic test_zero_reg();
    clear_mem();
    uut.dmem_q[0] = 32'd55;
    uut.imem_q[0] = enc_i(OP_LOAD, 0, 1, 16'd0);
    uut.imem_q[1] = enc_r(1, 1, 0, FN_ADD);
    uut.imem_q[2] = enc_r(0, 1, 2, FN_ADD);
    uut.imem_q[3] = enc_i(OP_LOAD, 0, 0, 16'd0);
    uut.imem_q[4] = enc_r(0, 0, 3, FN_SUB);
    do_reset();
    step();
    chk_wr("R9", 1'b0, 5'd0, 32'd0); step();
    chk_wr("R9", 1'b1, 5'd2, 32'd55); step();
    chk_wr("R9", 1'b0, 5'd0, 32'd0); step();
    chk_wr("R9", 1'b1, 5'd3, 32'd0); step();
  endtask

  task automatic test_flow();
    clear_mem();
    uut.dmem_q[0] = 32'd9;
    uut.dmem_q[1] = 32'd9;
    uut.dmem_q[2] = 32'd4;
    uut.imem_q[0]  = enc_i(OP_LOAD, 0, 1, 16'd0);
    uut.imem_q[1]  = enc_i(OP_LOAD, 0, 2, 16'd4);
    uut.imem_q[2]  = enc_i(OP_LOAD, 0, 3, 16'd8);
    uut.imem_q[3]  = enc_i(OP_BEQ, 1, 3, 16'd5);
    uut.imem_q[4]  = enc_i(OP_BEQ, 1, 2, 16'd4);
    uut.imem_q[9]  = enc_i(OP_BEQ, 0, 0, 16'hFFFC);
    uut.imem_q[6]  = {6'h3F, 26'h3FF_FFFF};
    uut.imem_q[7]  = enc_r(1, 2, 5, 6'h24);
    uut.imem_q[8]  = enc_j(OP_JMP, 26'd12);
    uut.imem_q[12] = enc_j(OP_JAL, 26'd20);
    uut.imem_q[20] = enc_r(31, 0, 4, FN_ADD);
    do_reset();
    step(); step(); step();
    chk_pc("R6", 32'd12);
    chk_wr("R6", 1'b0, 5'd0, 32'd0); step();
    chk_pc("R6", 32'd16);            step();
    chk_pc("R5", 32'd36);            step();
    chk_pc("R5", 32'd24);
    chk_wr("R10", 1'b0, 5'd0, 32'd0); step();
    chk_pc("R10", 32'd28);
    chk_wr("R10", 1'b0, 5'd0, 32'd0); step();
    chk_pc("R10", 32'd32);            step();
    chk_pc("R7", 32'd48);
    chk_wr("R12", 1'b1, 5'd31, 32'd52); step();
    chk_pc("R8", 32'd80);
    chk_wr("R8", 1'b1, 5'd4, 32'd52); step();
  endtask

  task automatic test_reset();
    clear_mem();
    uut.imem_q[0] = enc_r(4, 31, 3, FN_ADD);
    do_reset();
    chk_pc("R11", 32'd0);
    chk_wr("R11", 1'b1, 5'd3, 32'd0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #1;
    test_arith();
    test_store();
    test_zero_reg();
    test_flow();
    test_reset();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end
endmodule